// File: doc/BRIEF.md
# Latching PHY Quick-Status Register

This block is the quick-status word of a 100 Mbps Ethernet physical-layer device. It gathers the status bits that management software polls most often, so one read gives the whole picture. The word holds three kinds of bit. Some are constant or live (rate, duplex, priority pin). Seven are latch-high event flags that hold an event until the word is read. One link bit is latch-low and holds a link failure until the word is read.

Management logic reads the word combinationally on `rdata_o`. A one-cycle `rd_i` strobe marks a read, and at that clock edge the sticky bits reload from their live inputs. A write strobe `wr_i` loads the sticky storage, but only while `ovr_en_i` is high. Reset is synchronous, and while it is held the defaults are loaded.

Each clock edge, a small access decoder picks one of three operations:
- **OP_HOLD**: no access, or a write without override. Latch-high bits OR in their events, and the link bit ANDs in the link state.
- **OP_CLEAR**: a read. Every sticky bit takes its live input.
- **OP_LOAD**: a write with override. The sticky bits take the written data, merged with the live events.

The decoder moves to OP_LOAD on `wr_i & ovr_en_i`, whether or not `rd_i` is high. Otherwise it moves to OP_CLEAR on `rd_i`, and to OP_HOLD in every other case.

Top module: `phy_qstat_reg`

## Requirements
- R1: Bit 15 of `rdata_o` always reads 1 (100 Mbps).
- R2: Reserved bits 13, 12, 11, 4 and 3 always read 0, even after a write of all ones under override.
- R3: Bit 14 (duplex, 1 = full) is registered. While reset is held, it loads 0 when `prio_i`=1 and loads `dpx_en_i` when `prio_i`=0. After reset, at each edge it takes `duplex_i`. Writes do not change it.
- R4: Bit 2 always equals `prio_i` (1 = hardware, 0 = software).
- R5: The latch-high bits sit at these positions: bit 10 = signal loss, 9 = PLL lock failure, 8 = false carrier, 7 = invalid symbol, 6 = halt symbol, 5 = premature end, 1 = remote fault. A high event input sets its bit at that edge. Without a read or an override write, a set bit stays 1 after the event input returns to 0.
- R6: At a read edge (OP_CLEAR), each latch-high bit takes its live event value. An event that is high at the read edge therefore leaves its bit at 1.
- R7: Bit 0 (link valid) is latch-low. A low `link_ok_i` at an edge clears it, and it stays 0 until a read edge, which loads the current `link_ok_i`.
- R8: At a write edge with `ovr_en_i`=1 (OP_LOAD), each latch-high bit becomes `wdata_i` bit OR its live event, and bit 0 becomes `wdata_i[0]` AND `link_ok_i`. A write takes precedence over a read in the same cycle.
- R9: A write with `ovr_en_i`=0 has no effect on the word.
- R10: Reset clears all latch-high bits and bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prio_i | input | 1 | Priority pin state |
| dpx_en_i | input | 1 | Duplex default used at reset when prio_i is 0 |
| duplex_i | input | 1 | Live duplex state |
| link_ok_i | input | 1 | Live link valid |
| rem_fault_i | input | 1 | Remote fault event |
| pll_fail_i | input | 1 | PLL lock failure event |
| sig_loss_i | input | 1 | Receive signal loss event |
| false_car_i | input | 1 | False carrier event |
| bad_sym_i | input | 1 | Invalid symbol event |
| halt_sym_i | input | 1 | Halt symbol event |
| early_end_i | input | 1 | Premature end of stream event |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| ovr_en_i | input | 1 | Override enable that permits writes |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Status word |

## Verification
The assertions assume that every event input, the link and duplex inputs, and the strobes are synchronous to `clk` and settled at each rising edge. They also assume reset is applied synchronously for at least one edge. The bench drives every input 1 ns after a rising edge and holds it through the next one. Because of that, each stimulus maps to exactly one decoder operation. The bench samples `rdata_o` at the same offset after the edge that applies the operation.

// File: rtl/qs_pkg.sv
package qs_pkg;

    localparam int unsigned QS_W   = 16;
    localparam int unsigned NUM_LH = 7;

    localparam int unsigned POS_RATE   = 15;
    localparam int unsigned POS_DUPLEX = 14;
    localparam int unsigned POS_PRIO   = 2;
    localparam int unsigned POS_LINK   = 0;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_CLEAR = 2'd1,
        OP_LOAD  = 2'd2
    } qs_op_e;

    // Word position of each latch-high event, indexed by event number.
    function automatic int unsigned lh_pos(input int unsigned idx);
        int unsigned p;
        unique case (idx)
            0:       p = 10;
            1:       p = 9;
            2:       p = 8;
            3:       p = 7;
            4:       p = 6;
            5:       p = 5;
            default: p = 1;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/qs_access_ctl.sv
module qs_access_ctl
    import qs_pkg::*;
(
    input  logic   rd_i,
    input  logic   wr_i,
    input  logic   ovr_en_i,
    output qs_op_e op_o
);

    logic wr_eff;
    assign wr_eff = wr_i & ovr_en_i;

    always_comb begin
        unique casez ({wr_eff, rd_i})
            2'b1?:   op_o = OP_LOAD;
            2'b01:   op_o = OP_CLEAR;
            default: op_o = OP_HOLD;
        endcase
    end

endmodule

// File: rtl/qs_latch_bit.sv
module qs_latch_bit
    import qs_pkg::*;
#(
    parameter bit LATCH_LOW = 1'b0
) (
    input  logic   clk,
    input  logic   rst,
    input  qs_op_e op,
    input  logic   live,
    input  logic   wbit,
    output logic   q
);

    logic nxt;

    generate
        if (LATCH_LOW) begin : g_low
            always_comb begin
                unique case (op)
                    OP_CLEAR: nxt = live;
                    OP_LOAD:  nxt = wbit & live;
                    default:  nxt = q & live;
                endcase
            end
        end else begin : g_high
            always_comb begin
                unique case (op)
                    OP_CLEAR: nxt = live;
                    OP_LOAD:  nxt = wbit | live;
                    default:  nxt = q | live;
                endcase
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= nxt;
    end

endmodule

// File: rtl/phy_qstat_reg.sv
module phy_qstat_reg
    import qs_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        prio_i,
    input  logic        dpx_en_i,
    input  logic        duplex_i,
    input  logic        link_ok_i,
    input  logic        rem_fault_i,
    input  logic        pll_fail_i,
    input  logic        sig_loss_i,
    input  logic        false_car_i,
    input  logic        bad_sym_i,
    input  logic        halt_sym_i,
    input  logic        early_end_i,
    input  logic        rd_i,
    input  logic        wr_i,
    input  logic        ovr_en_i,
    input  logic [15:0] wdata_i,
    output logic [15:0] rdata_o
);

    qs_op_e             op;
    logic [NUM_LH-1:0]  evt;
    logic [NUM_LH-1:0]  lh_q;
    logic               link_q;
    logic               dpx_q;

    assign evt = {rem_fault_i, early_end_i, halt_sym_i, bad_sym_i,
                  false_car_i, pll_fail_i, sig_loss_i};

    qs_access_ctl u_ctl (
        .rd_i     (rd_i),
        .wr_i     (wr_i),
        .ovr_en_i (ovr_en_i),
        .op_o     (op)
    );

    for (genvar g = 0; g < NUM_LH; g++) begin : g_lh
        localparam int unsigned P = lh_pos(g);
        qs_latch_bit #(.LATCH_LOW(1'b0)) u_bit (
            .clk  (clk),
            .rst  (rst),
            .op   (op),
            .live (evt[g]),
            .wbit (wdata_i[P]),
            .q    (lh_q[g])
        );
    end

    qs_latch_bit #(.LATCH_LOW(1'b1)) u_link (
        .clk  (clk),
        .rst  (rst),
        .op   (op),
        .live (link_ok_i),
        .wbit (wdata_i[POS_LINK]),
        .q    (link_q)
    );

    // Duplex: reset default depends on the priority pin, then tracks live state.
    always_ff @(posedge clk) begin
        if (rst) dpx_q <= prio_i ? 1'b0 : dpx_en_i;
        else     dpx_q <= duplex_i;
    end

    always_comb begin
        rdata_o             = '0;
        rdata_o[POS_RATE]   = 1'b1;
        rdata_o[POS_DUPLEX] = dpx_q;
        rdata_o[POS_PRIO]   = prio_i;
        rdata_o[POS_LINK]   = link_q;
        for (int i = 0; i < NUM_LH; i++) begin
            rdata_o[lh_pos(i)] = lh_q[i];
        end
    end

endmodule

// File: rtl/qs_checker.sv
module qs_checker (
    input logic        clk,
    input logic        rst,
    input logic        duplex_i,
    input logic        link_ok_i,
    input logic        rem_fault_i,
    input logic        pll_fail_i,
    input logic        sig_loss_i,
    input logic        false_car_i,
    input logic        bad_sym_i,
    input logic        halt_sym_i,
    input logic        early_end_i,
    input logic        rd_i,
    input logic        wr_i,
    input logic        ovr_en_i,
    input logic [15:0] rdata_o
);

    localparam logic [15:0] LH_MASK = 16'h07E2;

    logic [15:0] evt16;
    logic        quiet;

    assign evt16 = {5'b0, sig_loss_i, pll_fail_i, false_car_i, bad_sym_i,
                    halt_sym_i, early_end_i, 3'b0, rem_fault_i, 1'b0};
    assign quiet = !rd_i && !(wr_i && ovr_en_i);

    p_lh_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        quiet |=> ((rdata_o & $past(rdata_o) & LH_MASK) == ($past(rdata_o) & LH_MASK)));

    p_event_sets_r6: assert property (@(posedge clk) disable iff (rst)
        (evt16 != 16'h0) |=> ((rdata_o & $past(evt16)) == $past(evt16)));

    p_link_drop_r7: assert property (@(posedge clk) disable iff (rst)
        !link_ok_i |=> !rdata_o[0]);

    p_link_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (quiet && !rdata_o[0]) |=> !rdata_o[0]);

    p_duplex_follow_r3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (rdata_o[14] == $past(duplex_i)));

endmodule

bind phy_qstat_reg qs_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .duplex_i    (duplex_i),
    .link_ok_i   (link_ok_i),
    .rem_fault_i (rem_fault_i),
    .pll_fail_i  (pll_fail_i),
    .sig_loss_i  (sig_loss_i),
    .false_car_i (false_car_i),
    .bad_sym_i   (bad_sym_i),
    .halt_sym_i  (halt_sym_i),
    .early_end_i (early_end_i),
    .rd_i        (rd_i),
    .wr_i        (wr_i),
    .ovr_en_i    (ovr_en_i),
    .rdata_o     (rdata_o)
);

// File: tb/phy_qstat_reg_test.sv
`timescale 1ns/1ps
module phy_qstat_reg_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        prio_i = 1'b0, dpx_en_i = 1'b1, duplex_i = 1'b1, link_ok_i = 1'b1;
    logic [6:0]  ev = '0;
    logic        rd_i = 1'b0, wr_i = 1'b0, ovr_en_i = 1'b0;
    logic [15:0] wdata_i = '0;
    logic [15:0] rdata_o;
    int          errors = 0;
    int          checks = 0;

    always #2.5 clk = ~clk;

    phy_qstat_reg uut (
        .clk (clk), .rst (rst), .prio_i (prio_i), .dpx_en_i (dpx_en_i),
        .duplex_i (duplex_i), .link_ok_i (link_ok_i),
        .rem_fault_i (ev[6]), .pll_fail_i (ev[1]), .sig_loss_i (ev[0]),
        .false_car_i (ev[2]), .bad_sym_i (ev[3]), .halt_sym_i (ev[4]),
        .early_end_i (ev[5]), .rd_i (rd_i), .wr_i (wr_i), .ovr_en_i (ovr_en_i),
        .wdata_i (wdata_i), .rdata_o (rdata_o)
    );

    // Event index -> word bit, per R5.
    function automatic int bpos(input int i);
        int t[7] = '{10, 9, 8, 7, 6, 5, 1};
        return t[i];
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic do_read();
        rd_i = 1'b1; step(); rd_i = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; prio_i = 1'b0; dpx_en_i = 1'b1; duplex_i = 1'b0;
        step();
        chk("R3 R10 R1 R2 reset prio=0", rdata_o, 16'hC000);
        prio_i = 1'b1; step();
        chk("R3 R4 R10 reset prio=1", rdata_o, 16'h8004);
        prio_i = 1'b0; rst = 1'b0; step();
        chk("R7 link low after reset", rdata_o, 16'h8000);
        do_read();
        chk("R7 read loads link", rdata_o, 16'h8001);
    endtask

    task automatic t_latch_high();
        for (int i = 0; i < 7; i++) begin
            ev[i] = 1'b1; step(); ev[i] = 1'b0;
            chk("R5 event sets", rdata_o, 16'h8001 | (16'h1 << bpos(i)));
            step(); step();
            chk("R5 event held", rdata_o, 16'h8001 | (16'h1 << bpos(i)));
            do_read();
            chk("R6 read clears", rdata_o, 16'h8001);
        end
    endtask

    task automatic t_read_event_present();
        ev[3] = 1'b1; step();
        do_read();
        chk("R6 event at read stays", rdata_o, 16'h8081);
        ev[3] = 1'b0; step();
        chk("R6 still latched", rdata_o, 16'h8081);
        do_read();
        chk("R6 cleared", rdata_o, 16'h8001);
    endtask

    task automatic t_latch_low();
        link_ok_i = 1'b0; step(); link_ok_i = 1'b1;
        chk("R7 link drop", rdata_o, 16'h8000);
        step(); step();
        chk("R7 drop held after recovery", rdata_o, 16'h8000);
        do_read();
        chk("R7 read restores link", rdata_o, 16'h8001);
    endtask

    task automatic t_write();
        ovr_en_i = 1'b1; wr_i = 1'b1; wdata_i = 16'hFFFF; step();
        chk("R8 R2 write all ones", rdata_o, 16'h87E3);
        wr_i = 1'b0; wdata_i = 16'h0000;
        wr_i = 1'b1; ev[0] = 1'b1; step(); wr_i = 1'b0; ev[0] = 1'b0;
        chk("R8 write zero keeps live event", rdata_o, 16'h8400);
        rd_i = 1'b1; wr_i = 1'b1; wdata_i = 16'h0201; step();
        rd_i = 1'b0; wr_i = 1'b0;
        chk("R8 write wins over read", rdata_o, 16'h8201);
        ovr_en_i = 1'b0; wr_i = 1'b1; wdata_i = 16'h0000; step(); wr_i = 1'b0;
        chk("R9 write without override ignored", rdata_o, 16'h8201);
        do_read();
        chk("R9 state cleared by read", rdata_o, 16'h8001);
    endtask

    task automatic t_duplex_prio();
        duplex_i = 1'b1; step();
        chk("R3 duplex follows", rdata_o, 16'hC001);
        prio_i = 1'b1; #1;
        chk("R4 priority live", rdata_o, 16'hC005);
        ovr_en_i = 1'b1; wr_i = 1'b1; wdata_i = 16'h0001; step();
        wr_i = 1'b0; ovr_en_i = 1'b0;
        chk("R3 write leaves duplex", rdata_o, 16'hC005);
        prio_i = 1'b0; duplex_i = 1'b0; step();
        chk("R3 R4 duplex half", rdata_o, 16'h8001);
    endtask

    initial begin
        t_reset();
        t_latch_high();
        t_read_event_present();
        t_latch_low();
        t_write();
        t_duplex_prio();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #100000;
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule